// File: doc/BRIEF.md
# PC Breakpoint Trigger Unit

This block holds four programmable breakpoint triggers and checks all sixteen instruction addresses of a fetch block against all of them at once. A trigger has a small configuration word and a comparison address. Software-side logic programs a trigger by presenting a trigger number, the new configuration word and the new address on a one-cycle update port. The new values take effect from the next clock edge.

The lookup is purely combinational over the stored trigger state. For every slot the block returns one bit that tells the fetch path to tag that instruction with a breakpoint exception. A trigger compares for equality, for greater-or-equal or for less-than. A trigger can be chained to the next-numbered trigger so that it only fires where both match. All hits are masked while the core runs in debug mode.

Top module: `bpt_unit`

## Requirements
- R1: After a cycle with `rst_n` low, every trigger is disarmed and `hit_vec` is all zero for any addresses until a trigger is written.
- R2: A write with `upd_valid` high loads `upd_cfg` and `upd_addr` into trigger `upd_idx` at that clock edge. The other triggers keep their state.
- R3: Configuration word layout: bit 0 arm, bit 1 select, bit 2 chain, bits 6:3 match mode. Match mode 0 hits a slot whose address equals the trigger address.
- R4: Match mode 2 hits a slot whose address is greater than or equal to the trigger address. The comparison is unsigned.
- R5: Match mode 3 hits a slot whose address is strictly less than the trigger address. The comparison is unsigned.
- R6: Match modes 1 and 4 to 15 never hit.
- R7: A trigger with the select bit set to 1 never hits.
- R8: A trigger with the chain bit set hits a slot only when the next-numbered trigger also matches that same slot.
- R9: Trigger 3 with its chain bit set never hits, because it has no partner.
- R10: While `dbg_mode` is high, `hit_vec` is all zero.
- R11: Each bit of `hit_vec` depends only on its own slot address and reflects the present inputs in the same cycle. Several slots can hit at once.
- R12: A trigger whose arm bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | 1 | Write one trigger this cycle |
| upd_idx | input | 2 | Number of the trigger to write |
| upd_cfg | input | 7 | New configuration word |
| upd_addr | input | 40 | New comparison address |
| dbg_mode | input | 1 | Core is in debug mode; masks all hits |
| pc_vec | input | 640 | Sixteen slot addresses; slot i in bits [40*i+39:40*i] |
| hit_vec | output | 16 | Per-slot breakpoint hit |

## Verification
The hardest case to reach is a chain. It needs two triggers to be programmed consistently, and then a slot address that satisfies one comparison but not the other. The bench rewrites trigger pairs so that the partner trigger matches either the same slot or a different one. It also places several slot addresses on both sides of each threshold within one fetch block. Each chain is therefore seen both firing and failing, and the equal, greater-or-equal and less-than bounds are hit exactly at their edges.

// File: rtl/bpt_pkg.sv
// Shared types for the breakpoint trigger unit.
// Assumes a 7-bit configuration word: arm, select, chain, 4-bit match mode.
package bpt_pkg;
    localparam int CFG_W = 7;

    typedef enum logic [3:0] {
        MODE_EQ = 4'd0,
        MODE_GE = 4'd2,
        MODE_LT = 4'd3
    } match_mode_e;

    typedef struct packed {
        logic [3:0] mode;   // bits 6:3
        logic       chain;  // bit 2
        logic       sel;    // bit 1: 1 = inactive kind
        logic       arm;    // bit 0
    } trig_cfg_t;
endpackage

// File: rtl/bpt_regs.sv
// Register bank for the triggers.
// Assumes one write per cycle; writes become visible after the clock edge.
module bpt_regs
    import bpt_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int VA_W  = 40,
    localparam int IDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_valid,
    input  logic [IDX_W-1:0]            upd_idx,
    input  logic [CFG_W-1:0]            upd_cfg,
    input  logic [VA_W-1:0]             upd_addr,
    output trig_cfg_t [NTRIG-1:0]       cfg_q,
    output logic [NTRIG-1:0][VA_W-1:0]  addr_q
);
    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        // Hold one trigger; clear it on reset, load it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[t]  <= '0;
                addr_q[t] <= '0;
            end else if (upd_valid && (upd_idx == IDX_W'(t))) begin
                cfg_q[t]  <= trig_cfg_t'(upd_cfg);
                addr_q[t] <= upd_addr;
            end
        end
    end
endmodule

// File: rtl/bpt_cmp.sv
// Compares one slot address against one trigger.
// Assumes unsigned addresses; unknown modes and select=1 never match.
module bpt_cmp
    import bpt_pkg::*;
#(
    parameter int VA_W = 40
) (
    input  trig_cfg_t        cfg,
    input  logic [VA_W-1:0]  taddr,
    input  logic [VA_W-1:0]  pc,
    output logic             raw
);
    // Select the comparison for the programmed mode and qualify it.
    always_comb begin
        logic m;
        case (cfg.mode)
            MODE_EQ: m = (pc == taddr);
            MODE_GE: m = (pc >= taddr);
            MODE_LT: m = (pc <  taddr);
            default: m = 1'b0;
        endcase
        raw = cfg.arm && !cfg.sel && m;
    end
endmodule

// File: rtl/bpt_chain.sv
// Combines the raw matches of all triggers for one slot.
// Assumes a chained trigger pairs with the next number; the last has no partner.
module bpt_chain #(
    parameter int NTRIG = 4
) (
    input  logic [NTRIG-1:0] raw,
    input  logic [NTRIG-1:0] chain,
    input  logic             dbg_mode,
    output logic             hit
);
    // Gate each trigger by its partner, OR them, and mask in debug mode.
    always_comb begin
        logic any;
        any = 1'b0;
        for (int t = 0; t < NTRIG; t++) begin
            if (t == NTRIG - 1)
                any = any | (raw[t] & ~chain[t]);
            else
                any = any | (raw[t] & (~chain[t] | raw[(t+1) % NTRIG]));
        end
        hit = any & ~dbg_mode;
    end
endmodule

// File: rtl/bpt_unit.sv
// Breakpoint trigger unit: four triggers against sixteen slot addresses.
// Assumes lookups are combinational over registered trigger state.
module bpt_unit
    import bpt_pkg::*;
#(
    parameter int NTRIG = 4,
    parameter int NSLOT = 16,
    parameter int VA_W  = 40,
    localparam int IDX_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_valid,
    input  logic [IDX_W-1:0]        upd_idx,
    input  logic [CFG_W-1:0]        upd_cfg,
    input  logic [VA_W-1:0]         upd_addr,
    input  logic                    dbg_mode,
    input  logic [NSLOT*VA_W-1:0]   pc_vec,
    output logic [NSLOT-1:0]        hit_vec
);
    trig_cfg_t [NTRIG-1:0]       cfg_q;
    logic [NTRIG-1:0][VA_W-1:0]  addr_q;
    logic [NTRIG-1:0]            chain_bits;
    logic [NSLOT*NTRIG-1:0]      raw_flat;

    bpt_regs #(.NTRIG(NTRIG), .VA_W(VA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_valid(upd_valid),
        .upd_idx  (upd_idx),
        .upd_cfg  (upd_cfg),
        .upd_addr (upd_addr),
        .cfg_q    (cfg_q),
        .addr_q   (addr_q)
    );

    // Collect the chain bits for the combiners.
    always_comb begin
        for (int t = 0; t < NTRIG; t++) chain_bits[t] = cfg_q[t].chain;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        for (genvar t = 0; t < NTRIG; t++) begin : g_trig
            bpt_cmp #(.VA_W(VA_W)) u_cmp (
                .cfg  (cfg_q[t]),
                .taddr(addr_q[t]),
                .pc   (pc_vec[s*VA_W +: VA_W]),
                .raw  (raw_flat[s*NTRIG + t])
            );
        end
        bpt_chain #(.NTRIG(NTRIG)) u_chain (
            .raw     (raw_flat[s*NTRIG +: NTRIG]),
            .chain   (chain_bits),
            .dbg_mode(dbg_mode),
            .hit     (hit_vec[s])
        );
    end
endmodule

// File: rtl/bpt_unit_chk.sv
// Property checker for bpt_unit, attached with bind.
// Assumes it sees the raw comparator outputs of the unit.
module bpt_unit_chk #(
    parameter int NTRIG = 4,
    parameter int NSLOT = 16,
    parameter int VA_W  = 40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   upd_valid,
    input logic                   dbg_mode,
    input logic [NSLOT*VA_W-1:0]  pc_vec,
    input logic [NSLOT*NTRIG-1:0] raw_flat,
    input logic [NSLOT-1:0]       hit_vec
);
    logic settled;

    // Mark that one full cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    a_r1_clear_after_reset: assert property (@(posedge clk)
        !rst_n |=> hit_vec == '0);

    a_r10_debug_masks: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> hit_vec == '0);

    a_r11_stable_without_change: assert property (@(posedge clk) disable iff (!rst_n)
        settled && $stable(pc_vec) && $stable(dbg_mode) && !$past(upd_valid)
        |-> $stable(hit_vec));

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        a_r8_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[s] |-> |raw_flat[s*NTRIG +: NTRIG]);
    end
endmodule

bind bpt_unit bpt_unit_chk #(.NTRIG(NTRIG), .NSLOT(NSLOT), .VA_W(VA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_valid(upd_valid),
    .dbg_mode (dbg_mode),
    .pc_vec   (pc_vec),
    .raw_flat (raw_flat),
    .hit_vec  (hit_vec)
);

// File: tb/sim_bpt_unit.sv
module sim_bpt_unit;
    localparam int NTRIG = 4;
    localparam int NSLOT = 16;
    localparam int VA_W  = 40;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  upd_valid = 1'b0;
    logic [1:0]            upd_idx = '0;
    logic [6:0]            upd_cfg = '0;
    logic [VA_W-1:0]       upd_addr = '0;
    logic                  dbg_mode = 1'b0;
    logic [NSLOT*VA_W-1:0] pc_vec = '0;
    logic [NSLOT-1:0]      hit_vec;

    int compared = 0;
    int mismatched = 0;

    logic [6:0]      m_cfg  [NTRIG];
    logic [VA_W-1:0] m_addr [NTRIG];
    logic [VA_W-1:0] pcs    [NSLOT];

    logic [NSLOT-1:0] exp_q [$];
    string            tag_q [$];
    event             probe_ev;

    always #10 clk = ~clk;

    bpt_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_cfg(upd_cfg), .upd_addr(upd_addr), .dbg_mode(dbg_mode),
        .pc_vec(pc_vec), .hit_vec(hit_vec)
    );

    function automatic logic [6:0] mk(bit arm, bit sel, bit chain, int mode);
        return {4'(mode), chain, sel, arm};
    endfunction

    // Per-trigger match, from the requirement text (R3-R7, R12).
    function automatic bit t_match(int t, logic [VA_W-1:0] pc);
        logic [6:0] c;
        bit m;
        c = m_cfg[t];
        case (c[6:3])
            4'd0: m = (pc == m_addr[t]);
            4'd2: m = (pc >= m_addr[t]);
            4'd3: m = (pc <  m_addr[t]);
            default: m = 0;
        endcase
        return c[0] && !c[1] && m;
    endfunction

    // Expected hits (R8, R9, R10).
    function automatic logic [NSLOT-1:0] model(bit dbg);
        logic [NSLOT-1:0] r;
        r = '0;
        for (int s = 0; s < NSLOT; s++) begin
            for (int t = 0; t < NTRIG; t++) begin
                if (t_match(t, pcs[s])) begin
                    if (!m_cfg[t][2]) r[s] = 1;
                    else if (t < NTRIG-1 && t_match(t+1, pcs[s])) r[s] = 1;
                end
            end
        end
        return dbg ? '0 : r;
    endfunction

    task automatic wr(int idx, logic [6:0] cfg, logic [VA_W-1:0] addr);
        @(negedge clk);
        upd_valid = 1; upd_idx = 2'(idx); upd_cfg = cfg; upd_addr = addr;
        @(negedge clk);
        upd_valid = 0;
        m_cfg[idx] = cfg; m_addr[idx] = addr;
    endtask

    task automatic seq_pcs(logic [VA_W-1:0] base);
        for (int s = 0; s < NSLOT; s++) pcs[s] = base + VA_W'(2*s);
    endtask

    // Driver: apply slot addresses, push the expected hit vector.
    task automatic probe(string tag, bit dbg, logic [NSLOT-1:0] hand = 'x);
        @(negedge clk);
        for (int s = 0; s < NSLOT; s++) pc_vec[s*VA_W +: VA_W] = pcs[s];
        dbg_mode = dbg;
        #2;
        if (!$isunknown(hand) && hand !== model(dbg)) begin
            mismatched++;
            $display("FAIL %s model=%h hand=%h", tag, model(dbg), hand);
        end
        exp_q.push_back(model(dbg));
        tag_q.push_back(tag);
        ->probe_ev;
    endtask

    // Monitor: pop and compare away from the clock edge.
    initial begin
        forever begin
            @(probe_ev);
            #1;
            while (exp_q.size() > 0) begin
                logic [NSLOT-1:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                compared++;
                if (hit_vec !== e) begin
                    mismatched++;
                    $display("FAIL %s actual=%h expected=%h", tg, hit_vec, e);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int t = 0; t < NTRIG; t++) begin m_cfg[t] = '0; m_addr[t] = '0; end
        seq_pcs(40'h0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: nothing configured, no hits, even at address 0
        probe("R1 reset", 0, 16'h0000);
        seq_pcs(40'h1000);
        probe("R1 reset other block", 0, 16'h0000);

        // R3: equal mode, slot 5 only
        wr(0, mk(1,0,0,0), 40'h100A);
        probe("R3 equal", 0, 16'h0020);
        // R11: several slots at once, GE on trigger 1
        wr(1, mk(1,0,0,2), 40'h1010);
        probe("R4 ge edge R11 multi", 0, 16'hFF20);
        // R2: writing trigger 2 keeps 0 and 1
        wr(2, mk(1,0,0,3), 40'h1004);
        probe("R5 lt R2 others kept", 0, 16'hFF23);
        // R10: debug mode masks all
        probe("R10 debug", 1, 16'h0000);
        probe("R10 debug released", 0, 16'hFF23);

        // R12 and R7 and R6
        wr(0, mk(0,0,0,0), 40'h100A);
        wr(1, mk(1,1,0,2), 40'h1010);
        wr(2, mk(1,0,0,1), 40'h1004);
        probe("R12 R7 R6 off", 0, 16'h0000);
        wr(2, mk(1,0,0,7), 40'h1004);
        probe("R6 mode 7", 0, 16'h0000);

        // R8: chained 0 with 1 both matching slot 3
        wr(0, mk(1,0,1,0), 40'h1006);
        wr(1, mk(1,0,0,2), 40'h1000);
        wr(2, '0, '0);
        probe("R8 chain both", 0, 16'hFFFF);
        wr(1, mk(1,0,0,0), 40'h1008);
        probe("R8 chain partner elsewhere", 0, 16'h0010);
        wr(1, mk(1,0,0,3), 40'h1006);
        probe("R8 chain partner miss", 0, 16'h0007);

        // R9: trigger 3 chained has no partner
        wr(0, '0, '0); wr(1, '0, '0);
        wr(3, mk(1,0,1,0), 40'h1000);
        probe("R9 last chained", 0, 16'h0000);
        wr(3, mk(1,0,0,0), 40'h1000);
        probe("R9 last unchained", 0, 16'h0001);

        // R4/R5 unsigned at top of range
        for (int s = 0; s < NSLOT; s++) pcs[s] = {VA_W{1'b1}} - VA_W'(s);
        wr(3, mk(1,0,0,3), {VA_W{1'b1}} - 40'd3);
        probe("R5 unsigned top", 0, 16'hFFF0);
        wr(3, mk(1,0,0,2), {VA_W{1'b1}} - 40'd3);
        probe("R4 unsigned top", 0, 16'h000F);

        // R1: reset clears configured triggers
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        for (int t = 0; t < NTRIG; t++) begin m_cfg[t] = '0; m_addr[t] = '0; end
        probe("R1 after re-reset", 0, 16'h0000);

        @(negedge clk);
        #5;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule